// File: doc/BRIEF.md
# Four-Phase Compute Handshake Sequencer

This block sits between a producer, a consumer and a single-rail datapath that has a start/done pair. It is a clocked sequencer. It samples the levels on its three input wires and moves its three output wires so that one return-to-zero transaction always runs in the same causal order.

On the way up, a producer request leads to a datapath start. The datapath's done then leads to a consumer request, and the consumer's acknowledge leads to the producer acknowledge. The producer acknowledge is therefore withheld until the consumer has taken the result. On the way down, the same chain runs again on falling levels. The datapath result is captured when done is seen high and is presented to the consumer bundled with the output request.

Each output edge appears one clock after the input level that enables it is sampled. If an input that should be steady moves at the wrong moment, the sequencer refuses to advance in that cycle and raises a sticky fault flag.

Top module: `hs4_ctrl`

## Requirements
- R1: While rst_n is low, and right after it is released, dp_start, req_out, ack_in and proto_err are 0 and data_out is all zeros. The sequencer then waits for req_in.
- R2: In the idle phase (all outputs low), if req_in is sampled high with dp_done and ack_out low, dp_start goes high on that clock edge.
- R3: While dp_start is high and req_out is low, if dp_done is sampled high (req_in high, ack_out low), req_out goes high on that edge. On the same edge, data_out takes the value of res_in sampled there.
- R4: While req_out is high and ack_in is low, if ack_out is sampled high (req_in and dp_done high), ack_in goes high on that edge.
- R5: With all three outputs high, if req_in is sampled low (dp_done and ack_out high), dp_start goes low on that edge.
- R6: With dp_start low and req_out and ack_in high, if dp_done is sampled low (req_in low, ack_out high), req_out goes low on that edge.
- R7: With only ack_in high, if ack_out is sampled low (req_in and dp_done low), ack_in goes low on that edge and the sequencer is idle again. A new transaction is accepted from then on.
- R8: data_out does not change while req_out stays high.
- R9: The phase expects certain levels on the inputs it is not waiting for. If any of them is off its expected level, no output changes on that edge and proto_err goes high. proto_err stays high until reset.
- R10: At most one of dp_start, req_out and ack_in changes on any single clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | 1 | Request from producer |
| ack_in | output | 1 | Acknowledge to producer |
| dp_start | output | 1 | Start to datapath |
| dp_done | input | 1 | Done from datapath |
| res_in | input | W | Datapath result |
| req_out | output | 1 | Request to consumer |
| ack_out | input | 1 | Acknowledge from consumer |
| data_out | output | W | Result bundled with req_out |
| proto_err | output | 1 | Sticky fault flag for out-of-order input |

## Verification
Some properties are checked on every cycle by the assertions:
- at most one output edge per clock;
- each rising output edge is preceded by its enabling input;
- the held result does not move while req_out is high;
- a flagged fault freezes the phase, and the flag, once set, stays set.

Other behaviour only the bench scenarios can show. This includes the exact captured value, the full falling-half order, the return to idle followed by a second transaction, and the response to random mixes of legal and out-of-order input edges, which the bench predicts from its own phase model.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_RUN   = 3'd1,
        PH_FWD   = 3'd2,
        PH_HELD  = 3'd3,
        PH_DRAIN = 3'd4,
        PH_RET   = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e ph;
        logic   start;
        logic   rout;
        logic   ain;
        logic   err;
    } seq_s;

    typedef struct packed {
        logic   ok_req;
        logic   ok_done;
        logic   ok_ack;
    } exp_s;

endpackage

// File: rtl/hs4_guard.sv
module hs4_guard
    import hs4_pkg::*;
(
    input  phase_e ph,
    input  logic   req_in,
    input  logic   done,
    input  logic   ack_out,
    output logic   viol,
    output logic   adv
);
    exp_s lvl;   // level each steady input must hold
    exp_s care;  // which inputs must hold steady in this phase

    always_comb begin
        lvl  = '0;
        care = '1;
        adv  = 1'b0;
        unique case (ph)
            PH_IDLE: begin
                care.ok_req = 1'b0;
                adv = req_in;
            end
            PH_RUN: begin
                lvl.ok_req   = 1'b1;
                care.ok_done = 1'b0;
                adv = done;
            end
            PH_FWD: begin
                lvl.ok_req  = 1'b1;
                lvl.ok_done = 1'b1;
                care.ok_ack = 1'b0;
                adv = ack_out;
            end
            PH_HELD: begin
                lvl.ok_done = 1'b1;
                lvl.ok_ack  = 1'b1;
                care.ok_req = 1'b0;
                adv = !req_in;
            end
            PH_DRAIN: begin
                lvl.ok_ack   = 1'b1;
                care.ok_done = 1'b0;
                adv = !done;
            end
            PH_RET: begin
                care.ok_ack = 1'b0;
                adv = !ack_out;
            end
            default: begin
                adv = 1'b0;
            end
        endcase
        viol = (care.ok_req  && (req_in  != lvl.ok_req))
            || (care.ok_done && (done    != lvl.ok_done))
            || (care.ok_ack  && (ack_out != lvl.ok_ack))
            || (ph > PH_RET);
    end
endmodule

// File: rtl/hs4_seq.sv
module hs4_seq
    import hs4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   viol,
    input  logic   adv,
    output phase_e ph,
    output logic   start,
    output logic   rout,
    output logic   ain,
    output logic   err,
    output logic   cap
);
    seq_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        cap = 1'b0;
        if (viol) begin
            s_d.err = 1'b1;
        end else if (adv) begin
            unique case (s_q.ph)
                PH_IDLE:  begin s_d.ph = PH_RUN;   s_d.start = 1'b1; end
                PH_RUN:   begin s_d.ph = PH_FWD;   s_d.rout  = 1'b1; cap = 1'b1; end
                PH_FWD:   begin s_d.ph = PH_HELD;  s_d.ain   = 1'b1; end
                PH_HELD:  begin s_d.ph = PH_DRAIN; s_d.start = 1'b0; end
                PH_DRAIN: begin s_d.ph = PH_RET;   s_d.rout  = 1'b0; end
                PH_RET:   begin s_d.ph = PH_IDLE;  s_d.ain   = 1'b0; end
                default:  begin s_d.ph = PH_IDLE; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, start: 1'b0, rout: 1'b0, ain: 1'b0, err: 1'b0};
        else        s_q <= s_d;
    end

    assign ph    = s_q.ph;
    assign start = s_q.start;
    assign rout  = s_q.rout;
    assign ain   = s_q.ain;
    assign err   = s_q.err;

    // R10: one output edge per clock at most
    assert_one_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start, rout, ain} ^ $past({start, rout, ain})) <= 1);

    // R9: a flagged fault freezes the phase
    assert_hold_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> $stable(ph) && err);

    // R9: fault flag is sticky
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/hs4_bundle.sv
module hs4_bundle #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] din,
    input  logic         rout,
    output logic [W-1:0] dout
);
    logic [W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (cap) data_d = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;

    // R8: bundled result holds while the output request is up
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rout && $past(rout)) |-> $stable(dout));
endmodule

// File: rtl/hs4_ctrl.sv
module hs4_ctrl
    import hs4_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_in,
    output logic         ack_in,
    output logic         dp_start,
    input  logic         dp_done,
    input  logic [W-1:0] res_in,
    output logic         req_out,
    input  logic         ack_out,
    output logic [W-1:0] data_out,
    output logic         proto_err
);
    phase_e ph;
    logic   viol, adv, cap;

    hs4_guard u_guard (
        .ph      (ph),
        .req_in  (req_in),
        .done    (dp_done),
        .ack_out (ack_out),
        .viol    (viol),
        .adv     (adv)
    );

    hs4_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .viol  (viol),
        .adv   (adv),
        .ph    (ph),
        .start (dp_start),
        .rout  (req_out),
        .ain   (ack_in),
        .err   (proto_err),
        .cap   (cap)
    );

    hs4_bundle #(.W(W)) u_bundle (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .din   (res_in),
        .rout  (req_out),
        .dout  (data_out)
    );

    // R2
    assert_start_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dp_start) |-> $past(req_in));
    // R3
    assert_rout_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_out) |-> $past(dp_done) && $past(dp_start));
    // R4
    assert_ain_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_in) |-> $past(ack_out) && $past(req_out));
    // R6
    assert_rout_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_out) |-> !$past(dp_done) && !$past(dp_start));
endmodule

// File: tb/sim_hs4_ctrl.sv
module sim_hs4_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_in = 1'b0, dp_done = 1'b0, ack_out = 1'b0;
    logic [W-1:0] res_in = '0;
    logic ack_in, dp_start, req_out, proto_err;
    logic [W-1:0] data_out;

    int checks = 0, errors = 0;
    bit finished = 0;
    int m_ph = 0;
    bit m_err = 0;
    logic [W-1:0] m_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hs4_ctrl #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack_in(ack_in),
        .dp_start(dp_start), .dp_done(dp_done), .res_in(res_in),
        .req_out(req_out), .ack_out(ack_out), .data_out(data_out),
        .proto_err(proto_err)
    );

    // expected {start, req_out, ack_in} for each phase of the order
    function automatic logic [2:0] outs_f(int p);
        case (p)
            0: return 3'b000;
            1: return 3'b100;
            2: return 3'b110;
            3: return 3'b111;
            4: return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    // which input is awaited: 0 req_in, 1 dp_done, 2 ack_out; target level
    function automatic int wait_sig(int p); return p % 3; endfunction
    function automatic bit wait_lvl(int p); return p < 3; endfunction

    // required steady level of a non-awaited input
    function automatic bit steady_lvl(int p, int sig);
        case (sig)
            0: return (p == 1 || p == 2);
            1: return (p == 2 || p == 3);
            default: return (p == 3 || p == 4);
        endcase
    endfunction

    function automatic bit bad_f(int p, bit r, bit d, bit a);
        bit v[3];
        v[0] = r; v[1] = d; v[2] = a;
        for (int s = 0; s < 3; s++)
            if (s != wait_sig(p) && v[s] != steady_lvl(p, s)) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [2:0] prev;
        bit v[3];
        prev = {dp_start, req_out, ack_in};
        @(posedge clk);
        #1;
        v[0] = req_in; v[1] = dp_done; v[2] = ack_out;
        if (bad_f(m_ph, req_in, dp_done, ack_out)) m_err = 1;
        else if (v[wait_sig(m_ph)] == wait_lvl(m_ph)) begin
            if (m_ph == 1) m_data = res_in;
            m_ph = (m_ph + 1) % 6;
        end
        chk("R2,R5 dp_start", W'(dp_start), W'(outs_f(m_ph)[2]));
        chk("R3,R6 req_out", W'(req_out), W'(outs_f(m_ph)[1]));
        chk("R4,R7 ack_in", W'(ack_in), W'(outs_f(m_ph)[0]));
        chk("R9 proto_err", W'(proto_err), W'(m_err));
        chk("R3,R8 data_out", data_out, m_data);
        chk("R10 single edge", W'($countones(prev ^ {dp_start, req_out, ack_in}) <= 1), W'(1));
    endtask

    task automatic do_reset();
        #1;
        rst_n = 0; req_in = 0; dp_done = 0; ack_out = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 outs in reset", W'({dp_start, req_out, ack_in, proto_err}), W'(0));
        rst_n = 1;
        m_ph = 0; m_err = 0; m_data = '0;
        @(posedge clk);
        #1;
        chk("R1 outs after reset", W'({dp_start, req_out, ack_in, proto_err}), W'(0));
        chk("R1 data after reset", data_out, '0);
    endtask

    task automatic set_in(bit r, bit d, bit a);
        req_in = r; dp_done = d; ack_out = a;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();

        // directed full transaction, R2..R7
        res_in = 16'hBEEF;
        set_in(1, 0, 0); tick(); chk("R2 start up", W'(dp_start), W'(1));
        tick(); chk("R2 waiting for done", W'(req_out), W'(0));
        set_in(1, 1, 0); tick(); chk("R3 req_out up", W'(req_out), W'(1));
        chk("R3 captured", data_out, 16'hBEEF);
        res_in = 16'h1234;
        set_in(1, 1, 1); tick(); chk("R4 ack_in up", W'(ack_in), W'(1));
        chk("R8 data held", data_out, 16'hBEEF);
        set_in(0, 1, 1); tick(); chk("R5 start down", W'(dp_start), W'(0));
        set_in(0, 0, 1); tick(); chk("R6 req_out down", W'(req_out), W'(0));
        set_in(0, 0, 0); tick(); chk("R7 ack_in down", W'(ack_in), W'(0));
        set_in(1, 0, 0); tick(); chk("R7 next accepted", W'(dp_start), W'(1));

        // R9: consumer ack arrives together with done
        set_in(1, 1, 1); tick();
        chk("R9 flag raised", W'(proto_err), W'(1));
        chk("R9 no req_out", W'(req_out), W'(0));
        set_in(1, 1, 0); tick();
        chk("R9 flag sticky", W'(proto_err), W'(1));

        // constrained random with periodic reset
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) do_reset();
            res_in = W'($urandom);
            if ($urandom % 25 == 0) begin
                set_in(1'($urandom), 1'($urandom), 1'($urandom));
            end else begin
                bit v[3];
                for (int s = 0; s < 3; s++) v[s] = steady_lvl(m_ph, s);
                v[wait_sig(m_ph)] = ($urandom % 2) ? wait_lvl(m_ph) : !wait_lvl(m_ph);
                set_in(v[0], v[1], v[2]);
            end
            tick();
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule